// File: doc/BRIEF.md
# Context-Keyed Branch Target Scrambler

This block sits between the front-end predictor and the arrays that hold indirect-branch and return-address targets. When the execution context changes, it derives a fresh key from a set of entropy inputs and identifiers. The key lives in a register that has no path to any software-visible port. Every target headed for storage is first combined with the key by XOR and then bit-reversed. Every target read back for prediction is bit-reversed again and XORed with the same key. A target learned under one context therefore decodes to an unrelated address under any other context.

The key comes from four sources. The first is a software entropy word picked by the current privilege level. The second is a hardware entropy word picked by the same level. The third is a hardware entropy word picked by the security state. The fourth is a packed identifier made of the process ID, the virtual-machine ID, the security state and the privilege level. These sources are folded into a seed. The seed then passes through a parameterised number of reversible Feistel rounds, one round per cycle. Each round mixes the bits through a non-linear function.

The write path is a valid/ready stream. An incoming target is accepted only when the downstream storage is ready and the key is ready. Back-pressure from storage passes straight through to the producer. While a key is being computed, the block accepts nothing. The read path is combinational, so decoding adds no cycle to the prediction path. A lookup reports a hit only while the key is ready.

Top module: `ctx_target_cipher`

## Requirements
- R1: After reset, `key_ready`, `wr_ready`, `st_valid` and `rd_hit` are all low until the first context switch completes, whatever `wr_valid`, `st_ready` and `rd_lookup` are.
- R2: A `ctx_req` sampled high at a rising edge samples the context inputs. `key_ready` is low after that edge and stays low for exactly ROUNDS clock cycles. It is high after the ROUNDS-th following edge.
- R3: A `ctx_req` that arrives while a key is being computed restarts the computation with the newly sampled inputs. `key_ready` rises ROUNDS cycles after the latest request, and the resulting key is the one the latest inputs alone give.
- R4: The stored word is `st_data[i] = (wr_target ^ key)[W-1-i]`, a bit reversal of the XOR. Consequently `st_data(a) ^ st_data(b)` equals the bit reversal of `a ^ b` under the same key.
- R5: Write stream rules: `st_valid` is high when `wr_valid` is high and the key is ready. `wr_ready` is high when `st_ready` is high and the key is ready. A transfer happens when `wr_valid` and `wr_ready` are both high. While the key is not ready, nothing is offered or accepted.
- R6: Read decode is combinational in the same cycle: `rd_target = reverse(rd_stored) ^ key`. A word produced by the write path decodes back to the original target under the same key.
- R7: `rd_hit` is high only when `rd_lookup` is high and the key is ready. It is low during a recompute.
- R8: Changing any one of the following and switching context changes the key: the selected software entropy word, the selected hardware level entropy word, the selected security-state entropy word, the process ID, the VM ID, the security state, or the privilege level.
- R9: Entropy slots that the privilege level (`ctx_priv`: 0 user, 1 kernel, 2 hypervisor, 3 firmware; slot p is bits [p*W +: W]) or the security state (`ctx_secure`: slot s is bits [s*W +: W]) does not select have no effect on the key.
- R10: The key is a deterministic function of the sampled inputs, so returning to an earlier context restores correct decoding of targets stored under it.
- R11: A target stored under one context and read under a different context decodes to a value other than the original.
- R12: Between context requests, the key is held. Neither write traffic nor changes on the context inputs without `ctx_req` alter the encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_req | input | 1 | Context switch request; samples the context inputs |
| ctx_priv | input | 2 | Privilege level (0 user, 1 kernel, 2 hypervisor, 3 firmware) |
| ctx_secure | input | 1 | Security state (0 non-secure, 1 secure) |
| ctx_asid | input | ASID_W | Process identifier |
| ctx_vmid | input | VMID_W | Virtual-machine identifier |
| sw_entropy | input | 4*W | Software entropy, one word per privilege level |
| hw_entropy_lvl | input | 4*W | Hardware entropy, one word per privilege level |
| hw_entropy_sec | input | 2*W | Hardware entropy, one word per security state |
| key_ready | output | 1 | Key valid and not being recomputed |
| wr_valid | input | 1 | Plain target offered for storage |
| wr_ready | output | 1 | Target accepted this cycle when valid |
| wr_target | input | W | Plain target to store |
| st_valid | output | 1 | Enciphered word offered to storage |
| st_ready | input | 1 | Storage can take a word |
| st_data | output | W | Enciphered word |
| rd_lookup | input | 1 | Prediction lookup in progress |
| rd_stored | input | W | Enciphered word read from storage |
| rd_hit | output | 1 | Decoded target usable |
| rd_target | output | W | Decoded target |

## Verification
The assertions rely on a few assumptions about the block's inputs. The context fields and entropy words only need to be meaningful in the cycle where `ctx_req` is high. A producer holds `wr_target` steady while `wr_valid` is high and `wr_ready` is low. The round-trip property also assumes that whenever `rd_stored` equals `st_data`, the word was produced under the current key. The stimulus changes inputs only at falling edges and sets up every context field before it raises `ctx_req`. It only loops `rd_stored` back from the write path under the key that is still active. Because the key has no port, the bench observes it through the enciphered image of a zero target.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_FW     = 2'd3
  } priv_e;

  localparam int NUM_LVL = 4;
  localparam int NUM_SEC = 2;
  localparam int ID_TAIL_W = 3; // security bit plus two privilege bits
endpackage

// File: rtl/tcs_key_engine.sv
module tcs_key_engine
  import tcs_pkg::*;
#(
  parameter int W      = 48,
  parameter int ROUNDS = 4,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctx_req,
  input  logic [1:0]           ctx_priv,
  input  logic                 ctx_secure,
  input  logic [ASID_W-1:0]    ctx_asid,
  input  logic [VMID_W-1:0]    ctx_vmid,
  input  logic [NUM_LVL*W-1:0] sw_entropy,
  input  logic [NUM_LVL*W-1:0] hw_entropy_lvl,
  input  logic [NUM_SEC*W-1:0] hw_entropy_sec,
  output logic [W-1:0]         key,
  output logic                 key_ready
);
  localparam int HW    = W / 2;
  localparam int ID_W  = ASID_W + VMID_W + ID_TAIL_W;
  localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);
  localparam logic [HW-1:0] RC_BASE = HW'(64'h9E3779B97F4A7C15);

  function automatic logic [HW-1:0] mix_f(input logic [HW-1:0] l);
    logic [HW-1:0] r1, r8, r2;
    r1 = {l[HW-2:0], l[HW-1]};
    r8 = {l[HW-9:0], l[HW-1:HW-8]};
    r2 = {l[HW-3:0], l[HW-1:HW-2]};
    return (r1 & r8) ^ r2;
  endfunction

  function automatic logic [W-1:0] feistel(input logic [W-1:0] x,
                                           input logic [CNT_W-1:0] r);
    logic [HW-1:0] lh, rh;
    lh = x[W-1:HW];
    rh = x[HW-1:0];
    return {rh ^ mix_f(lh) ^ (RC_BASE ^ HW'(r)), lh};
  endfunction

  logic [W-1:0] sw_sel, lvl_sel, sec_sel, sec_rot, id_mix, seed;
  logic [W-1:0] work, round_out;
  logic [CNT_W-1:0] cnt;
  logic busy, key_valid;

  always_comb begin
    sw_sel  = sw_entropy[int'(ctx_priv) * W +: W];
    lvl_sel = hw_entropy_lvl[int'(ctx_priv) * W +: W];
    sec_sel = hw_entropy_sec[int'(ctx_secure) * W +: W];
    sec_rot = {sec_sel[W-8:0], sec_sel[W-1:W-7]};
    id_mix  = {{(W-ID_W){1'b0}}, ctx_asid, ctx_vmid, ctx_secure, ctx_priv};
    seed    = sw_sel ^ lvl_sel ^ sec_rot ^ id_mix;
    round_out = feistel(work, cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      key_valid <= 1'b0;
      cnt       <= '0;
      work      <= '0;
      key       <= '0;
    end else if (ctx_req) begin
      busy <= 1'b1;
      cnt  <= '0;
      work <= seed;
    end else if (busy) begin
      work <= round_out;
      if (cnt == LAST) begin
        key       <= round_out;
        key_valid <= 1'b1;
        busy      <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign key_ready = key_valid & ~busy;

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_req |=> !key_ready);
  assert_round_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= LAST);
  assert_key_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && !ctx_req) |=> ($stable(key) && key_ready));
endmodule

// File: rtl/tcs_scramble.sv
module tcs_scramble #(
  parameter int W = 48
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] plain,
  output logic [W-1:0] coded
);
  logic [W-1:0] mixed;
  assign mixed = plain ^ key;
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign coded[i] = mixed[W-1-i];
  end
endmodule

// File: rtl/tcs_unscramble.sv
module tcs_unscramble #(
  parameter int W = 48
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] coded,
  output logic [W-1:0] plain
);
  logic [W-1:0] unrev;
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign unrev[i] = coded[W-1-i];
  end
  assign plain = unrev ^ key;
endmodule

// File: rtl/ctx_target_cipher.sv
module ctx_target_cipher
  import tcs_pkg::*;
#(
  parameter int W      = 48,
  parameter int ROUNDS = 4,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctx_req,
  input  logic [1:0]           ctx_priv,
  input  logic                 ctx_secure,
  input  logic [ASID_W-1:0]    ctx_asid,
  input  logic [VMID_W-1:0]    ctx_vmid,
  input  logic [NUM_LVL*W-1:0] sw_entropy,
  input  logic [NUM_LVL*W-1:0] hw_entropy_lvl,
  input  logic [NUM_SEC*W-1:0] hw_entropy_sec,
  output logic                 key_ready,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [W-1:0]         wr_target,
  output logic                 st_valid,
  input  logic                 st_ready,
  output logic [W-1:0]         st_data,
  input  logic                 rd_lookup,
  input  logic [W-1:0]         rd_stored,
  output logic                 rd_hit,
  output logic [W-1:0]         rd_target
);
  logic [W-1:0] key;

  tcs_key_engine #(.W(W), .ROUNDS(ROUNDS), .ASID_W(ASID_W), .VMID_W(VMID_W)) key_i (
    .clk, .rst_n, .ctx_req, .ctx_priv, .ctx_secure, .ctx_asid, .ctx_vmid,
    .sw_entropy, .hw_entropy_lvl, .hw_entropy_sec,
    .key, .key_ready
  );

  tcs_scramble #(.W(W)) enc_i (.key(key), .plain(wr_target), .coded(st_data));
  tcs_unscramble #(.W(W)) dec_i (.key(key), .coded(rd_stored), .plain(rd_target));

  assign st_valid = wr_valid & key_ready;
  assign wr_ready = st_ready & key_ready;
  assign rd_hit   = rd_lookup & key_ready;

  assert_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && rd_stored == st_data) |-> rd_target == wr_target);
  assert_quiet_on_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_req |=> (!wr_ready && !st_valid));
  assert_no_hit_on_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_req |=> !rd_hit);
endmodule

// File: tb/ctx_target_cipher_tb_top.sv
module ctx_target_cipher_tb_top;
  localparam int W = 48;
  localparam int ROUNDS = 4;
  localparam int ASID_W = 16;
  localparam int VMID_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctx_req = 1'b0;
  logic [1:0] ctx_priv = 2'd0;
  logic ctx_secure = 1'b0;
  logic [ASID_W-1:0] ctx_asid = '0;
  logic [VMID_W-1:0] ctx_vmid = '0;
  logic [4*W-1:0] sw_entropy = '0;
  logic [4*W-1:0] hw_entropy_lvl = '0;
  logic [2*W-1:0] hw_entropy_sec = '0;
  logic key_ready, wr_ready, st_valid, rd_hit;
  logic wr_valid = 1'b0;
  logic st_ready = 1'b0;
  logic rd_lookup = 1'b0;
  logic [W-1:0] wr_target = '0;
  logic [W-1:0] rd_stored = '0;
  logic [W-1:0] st_data, rd_target;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctx_target_cipher #(.W(W), .ROUNDS(ROUNDS), .ASID_W(ASID_W), .VMID_W(VMID_W)) dut_i (
    .clk, .rst_n, .ctx_req, .ctx_priv, .ctx_secure, .ctx_asid, .ctx_vmid,
    .sw_entropy, .hw_entropy_lvl, .hw_entropy_sec, .key_ready,
    .wr_valid, .wr_ready, .wr_target, .st_valid, .st_ready, .st_data,
    .rd_lookup, .rd_stored, .rd_hit, .rd_target
  );

  function automatic logic [W-1:0] rev(input logic [W-1:0] x);
    logic [W-1:0] y;
    for (int i = 0; i < W; i++) y[i] = x[W-1-i];
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  task automatic base_ctx();
    ctx_priv = 2'd1; ctx_secure = 1'b0;
    ctx_asid = 16'h1234; ctx_vmid = 16'h0042;
    sw_entropy     = {4{48'hA5C3_1F00_77E2}};
    hw_entropy_lvl = {4{48'h0F1E_2D3C_4B5A}};
    hw_entropy_sec = {2{48'h6655_4433_2211}};
  endtask

  task automatic switch_ctx();
    @(negedge clk) ctx_req = 1'b1;
    @(negedge clk) ctx_req = 1'b0;
    repeat (ROUNDS) @(negedge clk);
  endtask

  task automatic encode(input logic [W-1:0] t, output logic [W-1:0] c);
    wr_valid = 1'b1; st_ready = 1'b1; wr_target = t;
    #1 c = st_data;
    wr_valid = 1'b0;
  endtask

  task automatic decode(input logic [W-1:0] c, output logic [W-1:0] t);
    rd_stored = c; rd_lookup = 1'b1;
    #1 t = rd_target;
    rd_lookup = 1'b0;
  endtask

  task automatic t_reset();
    wr_valid = 1'b1; st_ready = 1'b1; rd_lookup = 1'b1;
    #1;
    chk(!key_ready, "R1 key_ready", W'(key_ready), 0);
    chk(!wr_ready && !st_valid, "R1 write idle", W'({wr_ready, st_valid}), 0);
    chk(!rd_hit, "R1 rd_hit", W'(rd_hit), 0);
    wr_valid = 1'b0; st_ready = 1'b0; rd_lookup = 1'b0;
  endtask

  task automatic t_latency();
    base_ctx();
    @(negedge clk) ctx_req = 1'b1;
    @(negedge clk) ctx_req = 1'b0;
    chk(!key_ready, "R2 low after request", W'(key_ready), 0);
    for (int i = 1; i < ROUNDS; i++) begin
      @(negedge clk);
      chk(!key_ready, "R2 low during rounds", W'(key_ready), 0);
    end
    @(negedge clk);
    chk(key_ready, "R2 high after rounds", W'(key_ready), 1);
  endtask

  task automatic t_handshake();
    wr_valid = 1'b1; st_ready = 1'b0; wr_target = 48'h1;
    #1;
    chk(st_valid && !wr_ready, "R5 stalled", W'({st_valid, wr_ready}), 2);
    st_ready = 1'b1;
    #1;
    chk(st_valid && wr_ready, "R5 flowing", W'({st_valid, wr_ready}), 3);
    @(negedge clk) ctx_req = 1'b1;
    @(negedge clk) ctx_req = 1'b0;
    #1;
    chk(!st_valid && !wr_ready, "R5 blocked while keying", W'({st_valid, wr_ready}), 0);
    wr_valid = 1'b0; st_ready = 1'b0;
    repeat (ROUNDS) @(negedge clk);
  endtask

  task automatic t_rdvalid();
    rd_lookup = 1'b0;
    #1 chk(!rd_hit, "R7 no lookup", W'(rd_hit), 0);
    rd_lookup = 1'b1;
    #1 chk(rd_hit, "R7 lookup ready", W'(rd_hit), 1);
    @(negedge clk) ctx_req = 1'b1;
    @(negedge clk) ctx_req = 1'b0;
    #1 chk(!rd_hit, "R7 lookup while keying", W'(rd_hit), 0);
    rd_lookup = 1'b0;
    repeat (ROUNDS) @(negedge clk);
  endtask

  task automatic t_linear();
    logic [W-1:0] ca, cb, cz;
    encode(48'h0, cz);
    encode(48'h8000_0000_0001, ca);
    encode(48'h0123_4567_89AB, cb);
    chk((ca ^ cb) == rev(48'h8000_0000_0001 ^ 48'h0123_4567_89AB), "R4 xor pair",
        ca ^ cb, rev(48'h8000_0000_0001 ^ 48'h0123_4567_89AB));
    chk((ca ^ cz) == rev(48'h8000_0000_0001), "R4 bit order", ca ^ cz,
        rev(48'h8000_0000_0001));
  endtask

  task automatic t_roundtrip();
    logic [W-1:0] vals [4];
    logic [W-1:0] c, p;
    vals[0] = '0; vals[1] = '1; vals[2] = 48'h8000_0000_0000; vals[3] = 48'h7FFE_DCBA_0010;
    foreach (vals[i]) begin
      encode(vals[i], c);
      decode(c, p);
      chk(p == vals[i], "R6 round trip", p, vals[i]);
    end
  endtask

  task automatic t_sensitivity();
    logic [W-1:0] k0, k;
    base_ctx(); switch_ctx(); encode('0, k0);
    for (int f = 0; f < 7; f++) begin
      base_ctx();
      case (f)
        0: sw_entropy[1*W +: W] = 48'hDEAD_BEEF_0001;
        1: hw_entropy_lvl[1*W +: W] = 48'h0000_0000_0100;
        2: hw_entropy_sec[0 +: W] = 48'h1111_0000_0000;
        3: ctx_asid = 16'h1235;
        4: ctx_vmid = 16'h8042;
        5: ctx_secure = 1'b1;
        default: ctx_priv = 2'd3;
      endcase
      switch_ctx(); encode('0, k);
      chk(k != k0, "R8 input changes key", k, ~k0);
    end
  endtask

  task automatic t_ignored();
    logic [W-1:0] k0, k;
    base_ctx(); switch_ctx(); encode('0, k0);
    sw_entropy[0 +: W] = 48'h1;
    sw_entropy[3*W +: W] = 48'hFFFF_0000_FFFF;
    hw_entropy_lvl[2*W +: W] = 48'h1357_9BDF_0246;
    hw_entropy_sec[1*W +: W] = 48'h0;
    switch_ctx(); encode('0, k);
    chk(k == k0, "R9 unselected slots ignored", k, k0);
  endtask

  task automatic t_cross_and_return();
    logic [W-1:0] t, c, p;
    t = 48'h0000_4000_1F80;
    base_ctx(); switch_ctx(); encode(t, c);
    ctx_asid = 16'h9999; switch_ctx();
    decode(c, p);
    chk(p != t, "R11 other context scrambles", p, ~t);
    base_ctx(); switch_ctx();
    decode(c, p);
    chk(p == t, "R10 return restores", p, t);
  endtask

  task automatic t_restart();
    logic [W-1:0] kb, k;
    base_ctx(); ctx_vmid = 16'h0777; switch_ctx(); encode('0, kb);
    base_ctx();
    @(negedge clk) ctx_req = 1'b1;
    @(negedge clk) ctx_req = 1'b0;
    @(negedge clk);
    ctx_vmid = 16'h0777; ctx_req = 1'b1;
    @(negedge clk) ctx_req = 1'b0;
    for (int i = 1; i < ROUNDS; i++) begin
      @(negedge clk);
      chk(!key_ready, "R3 restart keeps low", W'(key_ready), 0);
    end
    @(negedge clk);
    chk(key_ready, "R3 restart completes", W'(key_ready), 1);
    encode('0, k);
    chk(k == kb, "R3 latest inputs win", k, kb);
  endtask

  task automatic t_hold();
    logic [W-1:0] k0, k, c;
    base_ctx(); switch_ctx(); encode('0, k0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) encode(W'(i * 48'h0101_0101), c);
    end
    ctx_asid = 16'hFFFF; sw_entropy = '1; ctx_priv = 2'd2;
    repeat (3) @(negedge clk);
    encode('0, k);
    chk(k == k0, "R12 key held", k, k0);
    chk(key_ready, "R12 ready held", W'(key_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_handshake();
    t_rdvalid();
    t_linear();
    t_roundtrip();
    t_sensitivity();
    t_ignored();
    t_cross_and_return();
    t_restart();
    t_hold();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule